// File: doc/BRIEF.md
# Segmented Tapped Shift Register

This block is a serial delay line of NUM_SEG x SEG_LEN stages (4 x 16 = 64 by default). It is cut into equal segments, and the last stage of every segment is brought out as a tap. In chain mode the segments are linked end to end, so the input bit stream appears at each tap after 16, 32, 48 and 64 clocks. Every tap output is then reported as driven.

In load mode the taps between segments change role. The enable flag of each tap drops, and separate tap input ports take over as the entry points of the second and following segments. The serial input still feeds the first segment. All segments then fill at once, one bit per segment per clock, so the whole register is written in SEG_LEN clocks. The enable of the final tap also drops in this mode, which models a high-impedance output for use on a shared line.

The register changes state only on the rising clock edge. It holds its contents for as long as the clock is stopped. An asynchronous active-low reset clears every stage.

Top module: `tapped_sr`

## Requirements
- R1: While rst_n is low, every stage is cleared, so all tap_out bits read 0.
- R2: With ld_mode = 0, the first stage of segment k (k >= 1) takes the last stage of segment k-1 on each rising edge. A bit entered at ser_in therefore appears on tap_out[k] after 16*(k+1) clocks.
- R3: On every rising edge, in either mode, ser_in is shifted into the first stage of segment 0.
- R4: With ld_mode = 1, the first stage of segment k (k >= 1) takes tap_in[k-1] on each rising edge.
- R5: With ld_mode = 1, tap_oe reads all zeros. The final tap is reported as high impedance, and the intermediate tap positions act as inputs.
- R6: With ld_mode = 0, tap_oe reads all ones.
- R7: Within each segment, bits move one stage per clock in first-in first-out order. After 16 load clocks, tap_out[k] holds the first bit given to segment k. A following 64-clock chain read on tap_out[3] returns segment 3, then segment 2, then segment 1, then segment 0, each segment's bits in their entry order.
- R8: While the clock is stopped, tap_out keeps its value whatever happens on ser_in, tap_in and the other inputs that feed the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear of all stages |
| ser_in | input | 1 | Serial data into segment 0 |
| ld_mode | input | 1 | 0 = chain mode, 1 = parallel segment load |
| tap_in | input | NUM_SEG-1 | Segment entry data for segments 1..NUM_SEG-1 in load mode |
| tap_out | output | NUM_SEG | Last stage of each segment; bit k is the tap after stage 16*(k+1) |
| tap_oe | output | NUM_SEG | Per-tap drive enable; 0 means the tap is an input or is high impedance |

## Verification
The bound checker follows the register state on every edge. It checks that segment 0 takes ser_in, that each later segment's entry stage takes the previous segment's tail in chain mode or its tap input in load mode, and that bits move within a segment one stage per edge. It also checks the enable flags against the mode and the cleared state under reset. The end-to-end orderings are left to the bench scenarios: the 64-clock chain delay, the first-in-first-out readback after a 16-clock parallel load, and holding while the clock is stopped. These depend on long histories or on the clock itself being absent.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  parameter int unsigned DEF_SEG_LEN = 16;
  parameter int unsigned DEF_NUM_SEG = 4;

  typedef enum logic {
    MODE_CHAIN = 1'b0,
    MODE_LOAD  = 1'b1
  } tsr_mode_e;
endpackage

// File: rtl/tsr_segment.sv
// One segment of the delay line; q[0] is the entry stage, q[LEN-1] the tap.
module tsr_segment #(
  parameter int unsigned LEN = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           din,
  output logic [LEN-1:0] q
);
  logic [LEN-1:0] q_nxt;

  always_comb begin
    q_nxt = {q[LEN-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/tsr_feed.sv
// Selects the entry bit of every segment from the mode.
module tsr_feed
  import tsr_pkg::*;
#(
  parameter int unsigned NSEG = 4
) (
  input  logic            ser_in,
  input  tsr_mode_e       mode,
  input  logic [NSEG-2:0] tap_in,
  input  logic [NSEG-2:0] prev_tail,
  output logic [NSEG-1:0] seg_din
);
  always_comb begin
    seg_din[0] = ser_in;
  end

  for (genvar k = 1; k < NSEG; k++) begin : g_feed
    always_comb begin
      if (mode == MODE_LOAD) begin
        seg_din[k] = tap_in[k-1];
      end else begin
        seg_din[k] = prev_tail[k-1];
      end
    end
  end
endmodule

// File: rtl/tapped_sr.sv
module tapped_sr
  import tsr_pkg::*;
#(
  parameter int unsigned SEG_LEN = DEF_SEG_LEN,
  parameter int unsigned NUM_SEG = DEF_NUM_SEG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_in,
  input  logic               ld_mode,
  input  logic [NUM_SEG-2:0] tap_in,
  output logic [NUM_SEG-1:0] tap_out,
  output logic [NUM_SEG-1:0] tap_oe
);
  localparam int unsigned TOTAL = SEG_LEN * NUM_SEG;

  tsr_mode_e                       mode;
  logic [NUM_SEG-1:0][SEG_LEN-1:0] seg_q;
  logic [NUM_SEG-1:0]              seg_din;
  logic [NUM_SEG-2:0]              prev_tail;
  logic [TOTAL-1:0]                state_flat;

  always_comb begin
    mode = ld_mode ? MODE_LOAD : MODE_CHAIN;
  end

  for (genvar k = 0; k < NUM_SEG - 1; k++) begin : g_tail
    assign prev_tail[k] = seg_q[k][SEG_LEN-1];
  end

  tsr_feed #(
    .NSEG(NUM_SEG)
  ) u_feed (
    .ser_in   (ser_in),
    .mode     (mode),
    .tap_in   (tap_in),
    .prev_tail(prev_tail),
    .seg_din  (seg_din)
  );

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    tsr_segment #(
      .LEN(SEG_LEN)
    ) u_seg (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (seg_din[k]),
      .q    (seg_q[k])
    );
    assign tap_out[k] = seg_q[k][SEG_LEN-1];
  end

  always_comb begin
    tap_oe = (mode == MODE_CHAIN) ? '1 : '0;
  end

  assign state_flat = seg_q;
endmodule

// File: rtl/tapped_sr_chk.sv
module tapped_sr_chk #(
  parameter int unsigned SEG_LEN = 16,
  parameter int unsigned NUM_SEG = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ser_in,
  input logic                       ld_mode,
  input logic [NUM_SEG-2:0]         tap_in,
  input logic [NUM_SEG-1:0]         tap_oe,
  input logic [SEG_LEN*NUM_SEG-1:0] st
);
  localparam int unsigned TOTAL = SEG_LEN * NUM_SEG;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (st == '0 || !rst_n));

  // R3
  a_r3_serial_entry: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> st[0] == $past(ser_in));

  // R5
  a_r5_load_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mode |-> tap_oe == '0);

  // R6
  a_r6_chain_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_mode |-> &tap_oe);

  for (genvar k = 1; k < NUM_SEG; k++) begin : g_link
    // R2
    a_r2_chain_link: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_mode |=> st[k*SEG_LEN] == $past(st[k*SEG_LEN-1]));
    // R4
    a_r4_load_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ld_mode |=> st[k*SEG_LEN] == $past(tap_in[k-1]));
  end

  for (genvar j = 1; j < TOTAL; j++) begin : g_inner
    if ((j % SEG_LEN) != 0) begin : g_mid
      // R7
      a_r7_inner_shift: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st[j] == $past(st[j-1]));
    end
  end
endmodule

bind tapped_sr tapped_sr_chk #(
  .SEG_LEN(SEG_LEN),
  .NUM_SEG(NUM_SEG)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ser_in (ser_in),
  .ld_mode(ld_mode),
  .tap_in (tap_in),
  .tap_oe (tap_oe),
  .st     (state_flat)
);

// File: tb/sim_tapped_sr.sv
`timescale 1ns/1ps
module sim_tapped_sr;
  localparam int L = 16;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         clk_run = 1'b1;
  logic         rst_n = 1'b0;
  logic         ser_in = 1'b0;
  logic         ld_mode = 1'b0;
  logic [N-2:0] tap_in = '0;
  logic [N-1:0] tap_out;
  logic [N-1:0] tap_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit mq[N][$];

  tapped_sr u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ld_mode(ld_mode),
    .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe)
  );

  always begin
    #4;
    if (clk_run) clk = ~clk;
  end

  // Behavioural reference: one queue per segment, newest at the front.
  task automatic model_clear();
    for (int k = 0; k < N; k++) begin
      mq[k].delete();
      for (int j = 0; j < L; j++) mq[k].push_back(1'b0);
    end
  endtask

  initial model_clear();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_clear();
    end else begin
      bit feed[N];
      feed[0] = ser_in;
      for (int k = 1; k < N; k++) feed[k] = ld_mode ? tap_in[k-1] : mq[k-1][$];
      for (int k = 0; k < N; k++) begin
        mq[k].push_front(feed[k]);
        void'(mq[k].pop_back());
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    for (int k = 0; k < N; k++)
      chk(k == 0 ? "R3" : (ld_mode ? "R4" : "R2"), int'(tap_out[k]), int'(mq[k][$]));
    chk(ld_mode ? "R5" : "R6", int'(tap_oe), ld_mode ? 0 : (1 << N) - 1);
  endtask

  task automatic cycle();
    @(posedge clk);
    #2;
    compare();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [L-1:0] pat[N];
    logic [N-1:0] held;

    // R1: reset clears every stage
    ser_in = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", int'(tap_out), 0);
    chk("R6", int'(tap_oe), (1 << N) - 1);
    rst_n = 1'b1;

    // R2/R3/R6: chain mode with varied streams
    for (int i = 0; i < 200; i++) begin
      ser_in = (i < 40) ? 1'b1 : ((i < 80) ? i[0] : 1'($urandom));
      tap_in = N'($urandom);
      cycle();
    end

    // R2: single marker bit arrives at tap k after 16*(k+1) clocks
    ser_in = 1'b0;
    repeat (70) cycle();
    ser_in = 1'b1;
    cycle();
    ser_in = 1'b0;
    for (int c = 1; c < 64; c++) begin
      cycle();
      if (c == 15) chk("R2", int'(tap_out[0]), 1);
      if (c == 31) chk("R2", int'(tap_out[1]), 1);
      if (c == 47) chk("R2", int'(tap_out[2]), 1);
    end
    chk("R2", int'(tap_out[3]), 1);

    // R4/R5/R3: random load-mode traffic
    ld_mode = 1'b1;
    for (int i = 0; i < 60; i++) begin
      ser_in = 1'($urandom);
      tap_in = (N-1)'($urandom);
      cycle();
    end

    // R7: 16-clock parallel load, then chain readback on the last tap
    pat[0] = 16'hA5C3;
    pat[1] = 16'h0F1E;
    pat[2] = 16'h9B27;
    pat[3] = 16'h6D48;
    for (int j = 0; j < L; j++) begin
      ser_in = pat[0][j];
      for (int k = 1; k < N; k++) tap_in[k-1] = pat[k][j];
      cycle();
    end
    for (int k = 0; k < N; k++) chk("R7", int'(tap_out[k]), int'(pat[k][0]));
    chk("R5", int'(tap_oe), 0);
    ld_mode = 1'b0;
    ser_in = 1'b0;
    for (int i = 0; i < L * N; i++) begin
      #1;
      chk("R7", int'(tap_out[N-1]), int'(pat[N-1-i/L][i%L]));
      cycle();
    end

    // R8: clock stopped, inputs wiggle, contents hold
    for (int i = 0; i < 20; i++) begin
      ser_in = 1'($urandom);
      cycle();
    end
    held = tap_out;
    clk_run = 1'b0;
    for (int i = 0; i < 25; i++) begin
      ser_in = i[0];
      tap_in = (N-1)'(i);
      ld_mode = i[1];
      #8;
      chk("R8", int'(tap_out), int'(held));
    end
    ld_mode = 1'b0;
    #4;
    clk_run = 1'b1;
    for (int i = 0; i < 70; i++) begin
      ser_in = 1'($urandom);
      cycle();
    end

    // R1: asynchronous clear mid-run
    rst_n = 1'b0;
    #1;
    chk("R1", int'(tap_out), 0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    compare();
    finish_run();
  end
endmodule